// File: doc/BRIEF.md
# MDIO Management Master with Register Access

This block lets a processor run Ethernet management frames on an MDIO bus through a small set of 32-bit registers. Software first chooses the framing style and the MDC divider in the mode register. It then loads the port address and the register or device number into the address register and the 16-bit payload into the write-data register. A write to the command register with the start bit set launches one frame. While the frame runs, the busy flag reads as one. When it clears, a read result can be taken from the read-data register.

Two frame styles are supported. With the clause-select bit clear, each command is one complete register read or write. With it set, an access takes two commands. An address frame first sends the 16-bit register number from the write-data register. A separate read or write frame then uses that number. The meaning of the 2-bit command code therefore depends on the clause-select bit.

The block drives MDC itself, by dividing the system clock. It drives the data line through separate output, output-enable and input pins, and an external pull-up holds the line high when nothing drives it.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, busy reads 0, `mdc` and `mdio_oe` are low, the mode register reads 0x0000_0004 (divider field 4, clause select 0), and the address, write-data and read-data registers read 0.
- R2: The mode (offset 0x40), address (0x44) and write-data (0x48) registers store and return all 32 written bits. The command register (0x50) reads the busy flag at bit 16 and zero in every other bit.
- R3: A bus write to 0x50 with bit 8 set and a supported code in bits [1:0] starts a frame. Busy reads 1 from the next cycle for exactly 128*H clock cycles. H is mode bits [7:0], sampled at the start, with 0 treated as 1.
- R4: A start request that arrives while busy is 1 is ignored. This includes a request in the very cycle that the frame completes. No extra frame follows, the busy length does not change, and register writes made during a frame do not alter it.
- R5: With mode bit 8 = 0, a frame is sent MSB first as: 32 ones; start bits 01; opcode 10 for code 0 (read) or 01 for code 1 (write); port = address bits [12:8]; register = address bits [4:0]; turnaround 10; data = write-data bits [15:0].
- R6: With mode bit 8 = 1, the start bits are 00 and the field after the port is the device number in address bits [4:0]. Code 0 sends opcode 00 with write-data bits [15:0] as the register number, code 1 sends opcode 01 (write) and code 2 sends opcode 11 (read).
- R7: In a read frame, the master releases the line for the two turnaround bits and the 16 data bits. It samples the data MSB first on rising MDC edges and places it in bits [15:0] of 0x4C by the time busy clears. A line that no PHY drives reads as 0xFFFF.
- R8: `mdio_o` and `mdio_oe` never change while MDC stays high. They change only right after a falling MDC edge or when a frame starts.
- R9: Codes with no meaning in the current clause (2 and 3 with bit 8 = 0, 3 with bit 8 = 1) start nothing, and busy stays 0.
- R10: MDC is low whenever no frame runs, and within a frame each high phase and each low phase lasts H clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Register write strobe qualifier |
| bus_write | input | 1 | 1 for a write access |
| bus_addr | input | BUS_AW | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line as seen on the pin |

## Verification
The sharpest overlap is a new start request that lands in the same clock edge as the final falling MDC edge of the running frame. Busy is still one at that edge, so the request must be dropped. The bench times a start write to that exact edge from the known length of 128*H cycles. It then expects busy to read 0 one cycle later and the frame scoreboard to see no extra frame. A start that arrives mid-frame, together with a write-data change, is also checked: the frame scoreboard confirms that the frame in flight still carries its original payload.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam logic [7:0] OFS_MODE  = 8'h40;
  localparam logic [7:0] OFS_ADDR  = 8'h44;
  localparam logic [7:0] OFS_WDATA = 8'h48;
  localparam logic [7:0] OFS_RDATA = 8'h4C;
  localparam logic [7:0] OFS_CMD   = 8'h50;

  localparam int CLAUSE_BIT = 8;
  localparam int START_BIT  = 8;
  localparam int BUSY_BIT   = 16;

  // serial frame after the preamble, sent MSB first
  typedef struct packed {
    logic [1:0]  st;
    logic [1:0]  op;
    logic [4:0]  port;
    logic [4:0]  regdev;
    logic [1:0]  ta;
    logic [15:0] data;
  } frame_t;

  localparam int FRAME_W  = $bits(frame_t);
  localparam int HDR_BITS = 14;

endpackage

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs
  import mdio_mgmt_pkg::*;
#(
  parameter int BUS_AW  = 8,
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              busy_i,
  input  logic [15:0]       rd_data_i,
  output logic              c45_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [31:0]       addr_o,
  output logic [15:0]       wdata_o,
  output logic              start_o,
  output logic [1:0]        code_o
);

  logic [31:0] mode_q, mode_d;
  logic [31:0] addr_q, addr_d;
  logic [31:0] wdat_q, wdat_d;
  logic        wr_en;

  assign wr_en = bus_valid && bus_write;

  always_comb begin
    mode_d = mode_q;
    addr_d = addr_q;
    wdat_d = wdat_q;
    if (wr_en && bus_addr == BUS_AW'(OFS_MODE))  mode_d = bus_wdata;
    if (wr_en && bus_addr == BUS_AW'(OFS_ADDR))  addr_d = bus_wdata;
    if (wr_en && bus_addr == BUS_AW'(OFS_WDATA)) wdat_d = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 32'(DIV_RST);
      addr_q <= '0;
      wdat_q <= '0;
    end else begin
      mode_q <= mode_d;
      addr_q <= addr_d;
      wdat_q <= wdat_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      BUS_AW'(OFS_MODE):  bus_rdata = mode_q;
      BUS_AW'(OFS_ADDR):  bus_rdata = addr_q;
      BUS_AW'(OFS_WDATA): bus_rdata = wdat_q;
      BUS_AW'(OFS_RDATA): bus_rdata = {16'h0000, rd_data_i};
      BUS_AW'(OFS_CMD):   bus_rdata[BUSY_BIT] = busy_i;
      default:            bus_rdata = '0;
    endcase
  end

  assign c45_o   = mode_q[CLAUSE_BIT];
  assign div_o   = mode_q[DIV_W-1:0];
  assign addr_o  = addr_q;
  assign wdata_o = wdat_q[15:0];
  assign start_o = wr_en && (bus_addr == BUS_AW'(OFS_CMD)) && bus_wdata[START_BIT];
  assign code_o  = bus_wdata[1:0];

  // R2: the mode register changes only through a bus write to its offset
  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && bus_addr == BUS_AW'(OFS_MODE)) |=> $stable(mode_q));

endmodule

// File: rtl/mdio_mgmt_clkgen.sv
module mdio_mgmt_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);

  logic [DIV_W-1:0] half_q, half_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             tick;

  assign tick = run_i && (cnt_q == half_q - DIV_W'(1));

  always_comb begin
    half_d = half_q;
    cnt_d  = cnt_q;
    mdc_d  = mdc_q;
    if (load_i) begin
      half_d = (div_i == '0) ? DIV_W'(1) : div_i;
      cnt_d  = '0;
      mdc_d  = 1'b0;
    end else if (run_i) begin
      if (tick) begin
        cnt_d = '0;
        mdc_d = ~mdc_q;
      end else begin
        cnt_d = cnt_q + DIV_W'(1);
      end
    end else begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= DIV_W'(1);
      cnt_q  <= '0;
      mdc_q  <= 1'b0;
    end else begin
      half_q <= half_d;
      cnt_q  <= cnt_d;
      mdc_q  <= mdc_d;
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;

  // R10: MDC returns low and stays low whenever no frame runs
  p_mdc_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !load_i) |=> !mdc_q);

  // R10: a phase never outlasts the latched half period
  p_half_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q < half_q));

endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_i,
  input  frame_t      frame_i,
  input  logic        is_rd_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        mdio_i,
  output logic        accept_o,
  output logic        busy_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  output logic [15:0] rd_data_o
);

  localparam int TOTAL    = PRE_LEN + FRAME_W;
  localparam int IDX_W    = $clog2(TOTAL);
  localparam int FSEL_W   = $clog2(FRAME_W);
  localparam int TA_POS   = PRE_LEN + HDR_BITS;
  localparam int DATA_POS = TA_POS + 2;
  localparam int LAST_POS = TOTAL - 1;

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  frame_t           frame_q, frame_d;
  logic             rd_q, rd_d;
  logic [15:0]      rx_q, rx_d;
  logic [15:0]      rdat_q, rdat_d;
  logic [IDX_W-1:0] off;
  logic [FSEL_W-1:0] sel;
  logic             tx_bit;

  assign accept_o = req_i && !busy_q;

  always_comb begin
    busy_d  = busy_q;
    idx_d   = idx_q;
    frame_d = frame_q;
    rd_d    = rd_q;
    rx_d    = rx_q;
    rdat_d  = rdat_q;
    if (accept_o) begin
      busy_d  = 1'b1;
      idx_d   = '0;
      frame_d = frame_i;
      rd_d    = is_rd_i;
      rx_d    = '0;
    end else if (busy_q) begin
      if (rise_i && rd_q && idx_q >= IDX_W'(DATA_POS))
        rx_d = {rx_q[14:0], mdio_i};
      if (fall_i) begin
        if (idx_q == IDX_W'(LAST_POS)) begin
          busy_d = 1'b0;
          if (rd_q) rdat_d = rx_q;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      frame_q <= '0;
      rd_q    <= 1'b0;
      rx_q    <= '0;
      rdat_q  <= '0;
    end else begin
      busy_q  <= busy_d;
      idx_q   <= idx_d;
      frame_q <= frame_d;
      rd_q    <= rd_d;
      rx_q    <= rx_d;
      rdat_q  <= rdat_d;
    end
  end

  // bit position inside the frame word, counted from its MSB
  assign off    = idx_q - IDX_W'(PRE_LEN);
  assign sel    = FSEL_W'(FRAME_W - 1) - off[FSEL_W-1:0];
  assign tx_bit = (idx_q < IDX_W'(PRE_LEN)) ? 1'b1 : frame_q[sel];

  assign mdio_oe_o = busy_q && !(rd_q && idx_q >= IDX_W'(TA_POS));
  assign mdio_o    = mdio_oe_o ? tx_bit : 1'b0;
  assign busy_o    = busy_q;
  assign rd_data_o = rdat_q;

  // R3: an accepted start raises busy on the next edge
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> busy_q);

  // R4: a request during a frame leaves the latched frame untouched
  p_ignore_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && req_i) |=> $stable(frame_q));

  // R8: line outputs stay put across a clock in which MDC is high throughout
  p_stable_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_i && !rise_i && !accept_o && busy_q && $past(busy_q) && !$rose(busy_q))
      |=> $stable(mdio_oe_o));

  // R5: every frame opens by driving a preamble one
  p_preamble_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (mdio_oe_o && mdio_o));

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int BUS_AW  = 8,
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 4,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);

  logic [1:0]       rst_sync_q;
  logic             rst_s_n;
  logic             c45;
  logic [DIV_W-1:0] div;
  logic [31:0]      addr_r;
  logic [15:0]      wdata_r;
  logic             start;
  logic [1:0]       code;
  logic             code_ok;
  logic             is_rd;
  frame_t           frame;
  logic             accept;
  logic             busy;
  logic             rise, fall;
  logic [15:0]      rd_data;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  mdio_mgmt_regs #(
    .BUS_AW (BUS_AW),
    .DIV_W  (DIV_W),
    .DIV_RST(DIV_RST)
  ) regs_i (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .bus_valid(bus_valid),
    .bus_write(bus_write),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .busy_i   (busy),
    .rd_data_i(rd_data),
    .c45_o    (c45),
    .div_o    (div),
    .addr_o   (addr_r),
    .wdata_o  (wdata_r),
    .start_o  (start),
    .code_o   (code)
  );

  // frame encoder: the code meaning depends on the clause select
  always_comb begin
    frame        = '0;
    frame.port   = addr_r[12:8];
    frame.regdev = addr_r[4:0];
    frame.ta     = 2'b10;
    frame.data   = wdata_r;
    code_ok      = 1'b0;
    is_rd        = 1'b0;
    if (!c45) begin
      frame.st = 2'b01;
      case (code)
        2'd0: begin frame.op = 2'b10; code_ok = 1'b1; is_rd = 1'b1; end
        2'd1: begin frame.op = 2'b01; code_ok = 1'b1; end
        default: frame.op = 2'b00;
      endcase
    end else begin
      frame.st = 2'b00;
      case (code)
        2'd0: begin frame.op = 2'b00; code_ok = 1'b1; end
        2'd1: begin frame.op = 2'b01; code_ok = 1'b1; end
        2'd2: begin frame.op = 2'b11; code_ok = 1'b1; is_rd = 1'b1; end
        default: frame.op = 2'b00;
      endcase
    end
  end

  mdio_mgmt_engine #(
    .PRE_LEN(PRE_LEN)
  ) engine_i (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .req_i    (start && code_ok),
    .frame_i  (frame),
    .is_rd_i  (is_rd),
    .rise_i   (rise),
    .fall_i   (fall),
    .mdio_i   (mdio_i),
    .accept_o (accept),
    .busy_o   (busy),
    .mdio_o   (mdio_o),
    .mdio_oe_o(mdio_oe),
    .rd_data_o(rd_data)
  );

  mdio_mgmt_clkgen #(
    .DIV_W(DIV_W)
  ) clkgen_i (
    .clk   (clk),
    .rst_n (rst_s_n),
    .load_i(accept),
    .run_i (busy),
    .div_i (div),
    .mdc_o (mdc),
    .rise_o(rise),
    .fall_o(fall)
  );

  // R9: an unsupported code leaves the master idle
  p_bad_code_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (start && !code_ok && !busy) |=> !busy);

  // R8: line outputs hold while MDC stays high
  p_hold_mdc_high_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

endmodule

// File: tb/mdio_mgmt_master_tb_top.sv
module mdio_phy_model #(
  parameter logic [4:0] PORT = 5'd1,
  parameter bit         IS45 = 1'b0,
  parameter logic [4:0] DEV  = 5'd3
) (
  input  logic mdc,
  input  logic line,
  output logic drv_en,
  output logic drv_val
);
  logic [15:0] mem [32];
  logic [15:0] ptr;
  logic [13:0] hdr;
  logic [15:0] dat;
  logic [15:0] rd_val;
  logic        mine, rd_go;
  int          ones, pos, ne;

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = 16'hC000 | (16'(PORT) << 8) | 16'(i);
    ptr = '0; hdr = '0; dat = '0; rd_val = '0;
    mine = 1'b0; rd_go = 1'b0; ones = 0; pos = 0; ne = 0;
    drv_en = 1'b0; drv_val = 1'b0;
  end

  always @(posedge mdc) begin
    if (pos == 0) begin
      if (line) ones++;
      else begin
        if (ones >= 32) begin pos = 1; hdr = '0; end
        ones = 0;
      end
    end else begin
      pos++;
      if (pos <= 14) hdr = {hdr[12:0], line};
      else if (pos >= 17) dat = {dat[14:0], line};
      if (pos == 14) begin
        mine = (hdr[13:12] == (IS45 ? 2'b00 : 2'b01)) && (hdr[9:5] == PORT) &&
               (!IS45 || hdr[4:0] == DEV);
        if (mine && hdr[11:10] == (IS45 ? 2'b11 : 2'b10)) begin
          rd_go  = 1'b1;
          ne     = 0;
          rd_val = IS45 ? mem[ptr[4:0]] : mem[hdr[4:0]];
        end
      end
      if (pos == 32) begin
        if (mine) begin
          if (!IS45 && hdr[11:10] == 2'b01) mem[hdr[4:0]] = dat;
          if (IS45 && hdr[11:10] == 2'b00)  ptr = dat;
          if (IS45 && hdr[11:10] == 2'b01)  mem[ptr[4:0]] = dat;
        end
        pos = 0; ones = 0; mine = 1'b0;
      end
    end
  end

  always @(negedge mdc) begin
    if (rd_go) begin
      ne++;
      if (ne == 2) begin drv_en = 1'b1; drv_val = 1'b0; end
      else if (ne >= 3 && ne <= 18) drv_val = rd_val[18-ne];
      else if (ne == 19) begin drv_en = 1'b0; rd_go = 1'b0; end
    end
  end
endmodule

module mdio_mgmt_master_tb_top;
  localparam logic [7:0] A_MODE = 8'h40, A_ADDR = 8'h44, A_WDAT = 8'h48,
                         A_RDAT = 8'h4C, A_CMD = 8'h50;

  logic        clk, rst_n;
  logic        bus_valid, bus_write;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        p22_en, p22_v, p45_en, p45_v;
  logic        line;

  int total = 0, bad = 0;
  int cur_h = 4;
  logic [32:0] exp_q [$];
  int frames_seen = 0;

  assign line = mdio_oe ? mdio_o : p22_en ? p22_v : p45_en ? p45_v : 1'b1;

  mdio_mgmt_master dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(line));

  mdio_phy_model #(.PORT(5'd1), .IS45(1'b0)) phy22_i (.mdc(mdc), .line(line), .drv_en(p22_en), .drv_val(p22_v));
  mdio_phy_model #(.PORT(5'd5), .IS45(1'b1), .DEV(5'd3)) phy45_i (.mdc(mdc), .line(line), .drv_en(p45_en), .drv_val(p45_v));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=0x%08h exp=0x%08h", req, act, exp);
    end
  endtask

  // frame monitor: rebuilds each frame from the line and scores it
  int m_ones = 0, m_pos = 0, m_pre = 0;
  logic [31:0] m_bits;
  always @(posedge mdc) begin
    if (m_pos == 0) begin
      if (line) m_ones++;
      else begin
        m_pre = m_ones; m_ones = 0; m_pos = 1; m_bits = '0;
      end
    end else begin
      m_pos++;
      m_bits = {m_bits[30:0], line};
      if (m_pos == 32) begin
        frames_seen++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected frame", m_bits, 32'h0);
        end else begin
          logic [32:0] e;
          e = exp_q.pop_front();
          chk(m_pre == 32, "R5 preamble length", 32'(m_pre), 32'd32);
          chk(m_bits[31:18] == e[31:18], "R5/R6 frame header", 32'(m_bits[31:18]), 32'(e[31:18]));
          if (!e[32]) chk(m_bits[17:0] == e[17:0], "R5/R6 turnaround and data", 32'(m_bits[17:0]), 32'(e[17:0]));
        end
        m_pos = 0; m_ones = 0;
      end
    end
  end

  // MDC high-phase length
  int hi_cnt = 0, last_hi = 0;
  always @(negedge clk) begin
    if (mdc) hi_cnt++;
    else if (hi_cnt > 0) begin last_hi = hi_cnt; hi_cnt = 0; end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; #1;
    d = bus_rdata;
  endtask

  task automatic wait_idle(output int cnt);
    logic [31:0] d;
    cnt = 0;
    for (int k = 0; k < 20000; k++) begin
      bus_rd(A_CMD, d);
      if (!d[16]) break;
      cnt++;
    end
  endtask

  task automatic set_clause(input bit c45);
    logic [31:0] d;
    bus_rd(A_MODE, d);
    d[8] = c45;
    bus_wr(A_MODE, d);
  endtask

  // driver: program, push the expected frame, start, wait, check
  task automatic run_frame(input bit c45, input logic [1:0] code, input logic [4:0] pa,
                           input logic [4:0] rd5, input logic [15:0] wd,
                           input logic [15:0] exp_rd, input string tag);
    logic [1:0] st, op;
    bit is_rd;
    int cnt;
    logic [31:0] d;
    st = c45 ? 2'b00 : 2'b01;
    if (!c45) begin op = (code == 2'd0) ? 2'b10 : 2'b01; is_rd = (code == 2'd0); end
    else begin
      op = (code == 2'd0) ? 2'b00 : (code == 2'd1) ? 2'b01 : 2'b11;
      is_rd = (code == 2'd2);
    end
    set_clause(c45);
    bus_wr(A_ADDR, {19'd0, pa, 3'd0, rd5});
    bus_wr(A_WDAT, {16'd0, wd});
    exp_q.push_back({is_rd, st, op, pa, rd5, 2'b10, wd});
    bus_wr(A_CMD, 32'h100 | 32'(code));
    wait_idle(cnt);
    chk(cnt == 128 * cur_h, {"R3 busy length ", tag}, 32'(cnt), 32'(128 * cur_h));
    if (is_rd) begin
      bus_rd(A_RDAT, d);
      chk(d == {16'd0, exp_rd}, {"R7 read data ", tag}, d, {16'd0, exp_rd});
    end
  endtask

  initial begin
    int wd_cnt;
    wd_cnt = 0;
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'h0, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int cnt;
    bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    bus_rd(A_CMD, d);  chk(d == 32'h0, "R1 busy after reset", d, 32'h0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 mdc/oe low", {30'd0, mdc, mdio_oe}, 32'h0);
    bus_rd(A_MODE, d); chk(d == 32'h4, "R1 mode reset", d, 32'h4);
    bus_rd(A_ADDR, d); chk(d == 32'h0, "R1 addr reset", d, 32'h0);
    bus_rd(A_WDAT, d); chk(d == 32'h0, "R1 wdata reset", d, 32'h0);
    bus_rd(A_RDAT, d); chk(d == 32'h0, "R1 rdata reset", d, 32'h0);

    // R2 register round trips
    bus_wr(A_MODE, 32'h5A5A_0003); bus_rd(A_MODE, d); chk(d == 32'h5A5A_0003, "R2 mode", d, 32'h5A5A_0003);
    bus_wr(A_ADDR, 32'hFFFF_FFFF); bus_rd(A_ADDR, d); chk(d == 32'hFFFF_FFFF, "R2 addr", d, 32'hFFFF_FFFF);
    bus_wr(A_WDAT, 32'h1234_BEEF); bus_rd(A_WDAT, d); chk(d == 32'h1234_BEEF, "R2 wdata", d, 32'h1234_BEEF);
    bus_wr(A_MODE, 32'h5A5A_0002); cur_h = 2;
    set_clause(1'b1); bus_rd(A_MODE, d); chk(d == 32'h5A5A_0102, "R2 mode bits kept on clause change", d, 32'h5A5A_0102);
    bus_rd(A_CMD, d); chk(d == 32'h0, "R2 cmd idle readback", d, 32'h0);

    // R5 clause 22 write then read back, R7 reads
    run_frame(1'b0, 2'd1, 5'd1, 5'd3, 16'h1A2B, 16'h0, "c22 wr");
    run_frame(1'b0, 2'd0, 5'd1, 5'd3, 16'h0, 16'h1A2B, "c22 rd");
    run_frame(1'b0, 2'd0, 5'd1, 5'd7, 16'h0, 16'hC107, "c22 rd init");
    run_frame(1'b0, 2'd0, 5'd9, 5'd2, 16'h0, 16'hFFFF, "c22 rd no phy");
    run_frame(1'b0, 2'd0, 5'd5, 5'd3, 16'h0, 16'hFFFF, "c22 to c45 phy");

    // R6 clause 45 address, write, address, read
    run_frame(1'b1, 2'd0, 5'd5, 5'd3, 16'h0011, 16'h0, "c45 addr");
    run_frame(1'b1, 2'd1, 5'd5, 5'd3, 16'hCAFE, 16'h0, "c45 wr");
    run_frame(1'b1, 2'd0, 5'd5, 5'd3, 16'h0011, 16'h0, "c45 addr2");
    run_frame(1'b1, 2'd2, 5'd5, 5'd3, 16'h0, 16'hCAFE, "c45 rd");
    run_frame(1'b1, 2'd0, 5'd5, 5'd3, 16'h0004, 16'h0, "c45 addr3");
    run_frame(1'b1, 2'd2, 5'd5, 5'd3, 16'h0, 16'hC504, "c45 rd init");
    chk(last_hi == cur_h, "R10 mdc high phase", 32'(last_hi), 32'(cur_h));

    // R9 unsupported codes
    set_clause(1'b0);
    bus_wr(A_CMD, 32'h102); bus_rd(A_CMD, d); chk(d[16] == 1'b0, "R9 c22 code 2", d, 32'h0);
    bus_wr(A_CMD, 32'h103); bus_rd(A_CMD, d); chk(d[16] == 1'b0, "R9 c22 code 3", d, 32'h0);
    set_clause(1'b1);
    bus_wr(A_CMD, 32'h103); bus_rd(A_CMD, d); chk(d[16] == 1'b0, "R9 c45 code 3", d, 32'h0);

    // R4 start mid-frame and start at the completing edge
    set_clause(1'b0);
    bus_wr(A_ADDR, 32'h0000_0106);
    bus_wr(A_WDAT, 32'h0000_5AA5);
    exp_q.push_back({1'b0, 2'b01, 2'b01, 5'd1, 5'd6, 2'b10, 16'h5AA5});
    bus_wr(A_CMD, 32'h101);
    repeat (20) @(negedge clk);
    bus_wr(A_WDAT, 32'h0000_0F0F);
    bus_wr(A_CMD, 32'h100);
    wait_idle(cnt);
    chk(cnt == 128 * cur_h - 22, "R4 busy not extended", 32'(cnt), 32'(128 * cur_h - 22));
    bus_wr(A_ADDR, 32'h0000_0106);
    bus_rd(A_CMD, d); chk(d[16] == 1'b0, "R4 idle before edge test", d, 32'h0);
    exp_q.push_back({1'b0, 2'b01, 2'b01, 5'd1, 5'd6, 2'b10, 16'h0F0F});
    bus_wr(A_CMD, 32'h101);
    repeat (128 * cur_h - 1) @(negedge clk);
    bus_wr(A_CMD, 32'h101);
    bus_rd(A_CMD, d); chk(d[16] == 1'b0, "R4 start on completing edge ignored", d, 32'h0);
    run_frame(1'b0, 2'd0, 5'd1, 5'd6, 16'h0, 16'h0F0F, "R4 payload check");

    // R10 divider 0 treated as 1
    bus_wr(A_MODE, 32'h0000_0000); cur_h = 1;
    run_frame(1'b0, 2'd0, 5'd1, 5'd3, 16'h0, 16'h1A2B, "R10 div0");
    chk(last_hi == 1, "R10 mdc high phase div0", 32'(last_hi), 32'd1);
    chk(mdc == 1'b0, "R10 mdc low idle", {31'd0, mdc}, 32'h0);

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all expected frames seen", 32'(exp_q.size()), 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule